// File: doc/BRIEF.md
# Receive FIFO Idle Flush Timer

This block decides when a partly filled receive FIFO must be emptied toward the host. It watches the FIFO occupancy and a strobe that marks each byte written into it by the serial receiver. When the FIFO holds data but no new byte has arrived for a programmed number of milliseconds, it raises a flush request so the upstream packet logic collects the leftover bytes. A FIFO that reaches its full depth raises the request at once, with a reason flag that tells the two causes apart.

The millisecond base is divided down from the system clock by a prescaler that restarts with the countdown. This makes the idle window exactly `timeout x CLKS_PER_MS` clock cycles after the edge that restarted it. The timeout field is 8 bits wide and counts milliseconds. A value of 16 is the customary default, and a value of 0 behaves as 1.

The request pair works as a valid/ready handshake. `flush_req` is the valid side. It stays high, and the timer stays frozen, until `rd_ack` is sampled high in the same cycle. `rd_ack` without a pending request is ignored. The acknowledge edge restarts the idle window, so a FIFO that is still not empty is flushed again one full window later.

Top module: `rxto_flush_timer`

## Requirements
- R1: After reset, `flush_req` and `flush_full` are 0.
- R2: With a non-empty FIFO and no further byte, `flush_req` rises exactly `tmo_ms x CLKS_PER_MS` clock edges after the edge that sampled the last `byte_stb`, with `flush_full` = 0 (reason code 0 = idle timeout). This holds up to the largest value, 255.
- R3: Every sampled `byte_stb` restarts the full idle window. Bytes spaced closer than the window never cause a flush.
- R4: A `tmo_ms` value of 0 gives the same window as a value of 1.
- R5: While `fifo_level` is 0 the timer does not run, and no idle flush is raised. This includes the case where the FIFO is drained before the window ends.
- R6: Once raised, `flush_req` stays high until `rd_ack` is sampled high. Further bytes have no effect on it meanwhile.
- R7: An edge with `flush_req` and `rd_ack` both high clears `flush_req` and `flush_full` and restarts the idle window from that edge.
- R8: At the edge after `fifo_level` >= `FIFO_DEPTH` (384 by default), `flush_req` = 1 and `flush_full` = 1 (reason code 1 = full), whatever the timer state.
- R9: If the FIFO becomes full while an idle request is pending, `flush_full` changes to 1 and the request remains asserted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| byte_stb | input | 1 | One cycle per byte written into the FIFO |
| fifo_level | input | LEVEL_W (9) | Current FIFO occupancy in bytes |
| rd_ack | input | 1 | Upstream accepts the flush request (ready side) |
| tmo_ms | input | 8 | Idle timeout in milliseconds (0 treated as 1) |
| flush_req | output | 1 | Flush request (valid side), held until acknowledged |
| flush_full | output | 1 | Reason: 1 = FIFO full, 0 = idle timeout |

## Verification
The assertions assume that `fifo_level` never exceeds `FIFO_DEPTH`. They also assume that `CLKS_PER_MS` is at least 2, so that millisecond ticks are always separated. The bench drives every input on the falling clock edge and keeps `fifo_level` between 0 and the full depth. It changes `tmo_ms` only while the timer is being restarted. It raises `rd_ack` only for single cycles in which a request is pending, so that each expected rise of `flush_req` can be placed on an exact clock edge.

// File: rtl/rxto_pkg.sv
package rxto_pkg;
  typedef enum logic {RSN_IDLE = 1'b0, RSN_FULL = 1'b1} flush_rsn_e;

  function automatic logic [7:0] eff_timeout(input logic [7:0] raw);
    return (raw == 8'd0) ? 8'd1 : raw;
  endfunction
endpackage

// File: rtl/rxto_tick.sv
module rxto_tick #(
  parameter int CLKS_PER_MS = 100000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic restart,
  output logic tick
);
  localparam int PW = (CLKS_PER_MS > 1) ? $clog2(CLKS_PER_MS) : 1;
  localparam logic [PW-1:0] LAST = PW'(CLKS_PER_MS - 1);

  logic [PW-1:0] pre_q;

  assign tick = (pre_q == LAST) && !restart;

  always_ff @(posedge clk) begin
    if (!rst_n || restart || pre_q == LAST) pre_q <= '0;
    else                                   pre_q <= pre_q + 1'b1;
  end

  p_tick_gap_r2: assert property (@(posedge clk) disable iff (!rst_n)
    tick |=> !tick);
endmodule

// File: rtl/rxto_mscount.sv
module rxto_mscount
  import rxto_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       restart,
  input  logic       tick,
  input  logic [7:0] tmo_ms,
  output logic       expire
);
  logic [7:0] rem_q;

  assign expire = tick && (rem_q == 8'd1);

  always_ff @(posedge clk) begin
    if (!rst_n || restart)          rem_q <= eff_timeout(tmo_ms);
    else if (tick && rem_q != 8'd1) rem_q <= rem_q - 8'd1;
  end

  p_rem_nonzero_r4: assert property (@(posedge clk) disable iff (!rst_n)
    rem_q != 8'd0);
  p_rem_steady_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (!restart && !tick) |=> $stable(rem_q));
endmodule

// File: rtl/rxto_flush_ctl.sv
module rxto_flush_ctl
  import rxto_pkg::*;
#(
  parameter int FIFO_DEPTH = 384,
  parameter int LEVEL_W    = $clog2(FIFO_DEPTH + 1)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [LEVEL_W-1:0] fifo_level,
  input  logic               expire,
  input  logic               rd_ack,
  output logic               flush_req,
  output flush_rsn_e         flush_rsn
);
  localparam logic [LEVEL_W-1:0] FULL_LVL = LEVEL_W'(FIFO_DEPTH);

  logic is_full;
  assign is_full = (fifo_level >= FULL_LVL);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      flush_req <= 1'b0;
      flush_rsn <= RSN_IDLE;
    end else if (flush_req && rd_ack) begin
      flush_req <= 1'b0;
      flush_rsn <= RSN_IDLE;
    end else if (is_full) begin
      flush_req <= 1'b1;
      flush_rsn <= RSN_FULL;
    end else if (expire) begin
      flush_req <= 1'b1;
    end
  end

  p_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (flush_req && !rd_ack) |=> flush_req);
  p_full_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (is_full && !(flush_req && rd_ack)) |=> (flush_req && flush_rsn == RSN_FULL));
  p_rsn_valid_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (flush_rsn == RSN_FULL) |-> flush_req);
endmodule

// File: rtl/rxto_flush_timer.sv
module rxto_flush_timer
  import rxto_pkg::*;
#(
  parameter int CLKS_PER_MS = 100000,
  parameter int FIFO_DEPTH  = 384,
  parameter int LEVEL_W     = $clog2(FIFO_DEPTH + 1)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               byte_stb,
  input  logic [LEVEL_W-1:0] fifo_level,
  input  logic               rd_ack,
  input  logic [7:0]         tmo_ms,
  output logic               flush_req,
  output logic               flush_full
);
  logic       restart;
  logic       tick;
  logic       expire;
  flush_rsn_e rsn;

  // Window is held at its start while empty, on a byte, or while a request waits.
  assign restart    = byte_stb || (fifo_level == '0) || flush_req;
  assign flush_full = (rsn == RSN_FULL);

  rxto_tick #(.CLKS_PER_MS(CLKS_PER_MS)) u_tick (
    .clk(clk), .rst_n(rst_n), .restart(restart), .tick(tick)
  );

  rxto_mscount u_ms (
    .clk(clk), .rst_n(rst_n), .restart(restart), .tick(tick),
    .tmo_ms(tmo_ms), .expire(expire)
  );

  rxto_flush_ctl #(.FIFO_DEPTH(FIFO_DEPTH), .LEVEL_W(LEVEL_W)) u_ctl (
    .clk(clk), .rst_n(rst_n), .fifo_level(fifo_level), .expire(expire),
    .rd_ack(rd_ack), .flush_req(flush_req), .flush_rsn(rsn)
  );

  p_empty_r5: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(flush_req) && !flush_full) |-> ($past(fifo_level) != '0));
  p_fall_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(flush_req) |-> $past(rd_ack));
endmodule

// File: tb/tb_rxto_flush_timer.sv
module tb_rxto_flush_timer;
  localparam int N     = 10;
  localparam int DEPTH = 384;
  localparam int LW    = $clog2(DEPTH + 1);

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          byte_stb = 1'b0;
  logic [LW-1:0] fifo_level = '0;
  logic          rd_ack = 1'b0;
  logic [7:0]    tmo_ms = 8'd16;
  logic          flush_req, flush_full;

  int vectors = 0, miscompares = 0, cyc = 0;
  int exp_cyc_q[$];
  bit exp_rsn_q[$];
  bit prev_req = 1'b0;
  bit done = 1'b0;

  always #5 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  rxto_flush_timer #(.CLKS_PER_MS(N), .FIFO_DEPTH(DEPTH)) dut (
    .clk(clk), .rst_n(rst_n), .byte_stb(byte_stb), .fifo_level(fifo_level),
    .rd_ack(rd_ack), .tmo_ms(tmo_ms), .flush_req(flush_req), .flush_full(flush_full)
  );

  task automatic chk(input string req, input int act, input int exp);
    vectors++;
    if (act != exp) begin
      miscompares++;
      $display("FAIL %s actual=%0d expected=%0d at cycle %0d", req, act, exp, cyc);
    end
  endtask

  task automatic expect_rise(input int at, input bit rsn);
    exp_cyc_q.push_back(at);
    exp_rsn_q.push_back(rsn);
  endtask

  // Monitor: compare every rising request against the scoreboard.
  always @(negedge clk) begin
    if (rst_n && flush_req && !prev_req) begin
      if (exp_cyc_q.size() == 0) chk("R5 unexpected flush", 1, 0);
      else begin
        int ec;
        bit er;
        ec = exp_cyc_q.pop_front();
        er = exp_rsn_q.pop_front();
        chk("R2 rise cycle", cyc, ec);
        chk("R8 reason", int'(flush_full), int'(er));
      end
    end
    prev_req <= flush_req;
  end

  task automatic wait_cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  // Drives one byte; returns the edge index that samples it.
  task automatic send_byte(output int edge_no);
    @(negedge clk);
    byte_stb = 1'b1;
    edge_no = cyc + 1;
    @(negedge clk);
    byte_stb = 1'b0;
  endtask

  task automatic wait_req(input int limit);
    for (int i = 0; i < limit && !flush_req; i++) @(negedge clk);
  endtask

  task automatic do_ack(input int new_level, input int rearm_t);
    int a;
    @(negedge clk);
    rd_ack = 1'b1;
    fifo_level = LW'(new_level);
    a = cyc + 1;
    if (rearm_t > 0) expect_rise(a + rearm_t * N, 1'b0);
    @(negedge clk);
    rd_ack = 1'b0;
    chk("R7 cleared after ack", int'(flush_req), 0);
    chk("R7 reason cleared", int'(flush_full), 0);
  endtask

  initial begin
    int e;
    wait_cyc(3);
    chk("R1 req after reset", int'(flush_req), 0);
    chk("R1 reason after reset", int'(flush_full), 0);
    rst_n = 1'b1;
    wait_cyc(2);

    // R2 basic window, R6 hold, R7 rearm
    tmo_ms = 8'd3; fifo_level = LW'(1);
    send_byte(e); expect_rise(e + 30, 1'b0);
    wait_req(60);
    send_byte(e);
    wait_cyc(5);
    chk("R6 held while pending", int'(flush_req), 1);
    do_ack(4, 3);
    wait_req(60);
    chk("R7 rearmed flush", int'(flush_req), 1);
    do_ack(0, 0);

    // R3 bytes spaced inside window
    fifo_level = LW'(5);
    for (int k = 0; k < 4; k++) begin send_byte(e); wait_cyc(18); end
    chk("R3 no flush while bytes arrive", int'(flush_req), 0);
    send_byte(e); expect_rise(e + 30, 1'b0);
    wait_req(60);
    chk("R3 flush after last byte", int'(flush_req), 1);
    do_ack(0, 0);

    // R4 zero treated as one
    tmo_ms = 8'd0; fifo_level = LW'(2);
    send_byte(e); expect_rise(e + N, 1'b0);
    wait_req(30);
    chk("R4 zero timeout", int'(flush_req), 1);
    do_ack(0, 0);

    // R5 empty FIFO and drained FIFO
    tmo_ms = 8'd1; fifo_level = '0;
    send_byte(e);
    wait_cyc(40);
    chk("R5 empty no flush", int'(flush_req), 0);
    fifo_level = LW'(3);
    send_byte(e);
    wait_cyc(4);
    fifo_level = '0;
    wait_cyc(40);
    chk("R5 drained no flush", int'(flush_req), 0);

    // R8 full overrides timer
    tmo_ms = 8'd3; fifo_level = LW'(1);
    send_byte(e);
    wait_cyc(4);
    @(negedge clk);
    fifo_level = LW'(DEPTH);
    expect_rise(cyc + 1, 1'b1);
    wait_cyc(2);
    chk("R8 full reason", int'(flush_full), 1);
    do_ack(0, 0);

    // R9 upgrade of pending idle request
    tmo_ms = 8'd1; fifo_level = LW'(1);
    send_byte(e); expect_rise(e + N, 1'b0);
    wait_req(30);
    fifo_level = LW'(DEPTH);
    wait_cyc(2);
    chk("R9 reason upgraded", int'(flush_full), 1);
    chk("R9 request held", int'(flush_req), 1);
    do_ack(0, 0);

    // R2 largest timeout
    tmo_ms = 8'd255; fifo_level = LW'(1);
    send_byte(e); expect_rise(e + 255 * N, 1'b0);
    wait_req(2700);
    chk("R2 max timeout flush", int'(flush_req), 1);
    do_ack(0, 0);

    wait_cyc(5);
    chk("R2 scoreboard drained", exp_cyc_q.size(), 0);
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

  initial begin
    #1_000_000;
    if (!done) begin
      miscompares++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
    end
  end
endmodule